// File: doc/BRIEF.md
# Rate-Estimating Cache Victim Selector

This block chooses which way of a four-way set-associative cache to evict when a line must be filled. It does not keep tags or data. It keeps reference statistics for every set. Each set has one global counter that advances on every access to the set. Each way has a local counter that advances when that way hits. The ratio of the two is a running estimate of how often the way is referenced. The way with the lowest estimate is the one least likely to be needed again, so it becomes the victim.

The cache controller reports every lookup with `acc_valid`, the set number, a hit flag and the hit way. When it needs room it raises `fill_req` for one cycle with the set number. One clock later the block presents the chosen way on `victim_way` with `victim_valid` high. On that same edge the block takes the chosen way as evicted and refilled. Its local counter is zeroed and it is marked valid.

A small control machine has two named states. `S_IDLE` means no victim is presented. `S_GRANT` means a victim is on the output. There are four transitions:
- `fill_req` moves `S_IDLE` to `S_GRANT`.
- `fill_req` keeps the block in `S_GRANT`.
- No request returns `S_GRANT` to `S_IDLE`.
- No request keeps the block in `S_IDLE`.

Top module: `rate_victim_sel`

## Requirements
- R1: While reset is asserted, and after it is released, `victim_valid` is low. Every way of every set starts invalid, with all counters at zero.
- R2: `victim_valid` is high in exactly the cycle after a cycle with `fill_req` high, and low in every other cycle.
- R3: If the addressed set holds any invalid way, the victim is the invalid way with the lowest index.
- R4: If all four ways are valid, the victim's local count is no larger than that of any other way in the set. Local count divided by the set's global count is the estimated reference rate, and all ways in a set share one denominator.
- R5: When several valid ways share the lowest count, the victim is one of them. The choice is tied way number (lfsr[1:0] mod number_of_tied_ways), counted from the lowest index upward.
- R6: Each access adds one to the addressed set's global counter at the next clock edge. A hit also adds one to the hit way's local counter. A miss leaves every local counter unchanged.
- R7: On the edge where a victim is registered, that way's local counter becomes zero and the way becomes valid. This discards its history, and the clear overrides a hit to the same way on that edge.
- R8: Counters are 8 bits wide, so the maximum value is 255. An access to a set whose global counter is 255 first halves (floor) the global counter and every local counter of that set, then applies the increments of R6. This keeps every local count at or below the global count.
- R9: Accesses and fills to one set leave the counters and valid flags of every other set unchanged.
- R10: The tie-break source is a free-running 16-bit Fibonacci LFSR. It is seeded with 16'hACE1, shifts left each clock, and feeds bit15^bit13^bit12^bit10 into bit 0, so it never holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A lookup happened this cycle |
| acc_set | input | SET_W | Set index of the lookup |
| acc_hit | input | 1 | The lookup hit |
| acc_way | input | WAY_W | Way that hit |
| fill_req | input | 1 | Request a victim for a fill |
| fill_set | input | SET_W | Set index of the fill |
| victim_valid | output | 1 | Victim is presented this cycle |
| victim_way | output | WAY_W | Chosen victim way |

## Verification
The bench builds the block with eight sets, four ways and 8-bit counters. With 8-bit counters, the halving rule of R8 is reached within about 260 accesses to one set. That run ends with two ways collapsing into a tie, which a bench can observe. Eight sets are enough to keep distinct sets busy side by side, so leakage between sets would show up at the victim output. Four ways make all tie sizes from one to four possible, which exercises the modulo selection.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_GRANT = 1'b1
    } grant_state_e;
endpackage

// File: rtl/rvs_lfsr.sv
module rvs_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] state
);
    logic feedback;

    assign feedback = state[15] ^ state[13] ^ state[12] ^ state[10];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[14:0], feedback};
    end
endmodule

// File: rtl/rvs_pick.sv
module rvs_pick #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][CNT_W-1:0] loc,
    input  logic [WAY_W-1:0]           rnd,
    output logic [WAY_W-1:0]           way
);
    logic [CNT_W-1:0] min_cnt;
    logic [WAYS-1:0]  tied;
    logic [WAY_W:0]   n_tied;
    logic [WAY_W:0]   slot;
    logic [WAY_W:0]   seen;
    logic             taken;

    always_comb begin
        min_cnt = '1;
        for (int w = 0; w < WAYS; w++)
            if (loc[w] < min_cnt) min_cnt = loc[w];

        n_tied = '0;
        for (int w = 0; w < WAYS; w++) begin
            tied[w] = (loc[w] == min_cnt);
            n_tied  = n_tied + {{WAY_W{1'b0}}, tied[w]};
        end

        slot  = {1'b0, rnd} % n_tied;
        seen  = '0;
        taken = 1'b0;
        way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (tied[w]) begin
                if (!taken && seen == slot) begin
                    way   = WAY_W'(w);
                    taken = 1'b1;
                end
                seen = seen + 1'b1;
            end
        end

        // an empty way always wins, lowest index first
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid[w]) way = WAY_W'(w);
    end
endmodule

// File: rtl/rvs_set_stats.sv
module rvs_set_stats #(
    parameter int NUM_SETS = 64,
    parameter int WAYS     = 4,
    parameter int CNT_W    = 8,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic [SET_W-1:0]           acc_set,
    input  logic                       acc_hit,
    input  logic [WAY_W-1:0]           acc_way,
    input  logic                       evict_en,
    input  logic [SET_W-1:0]           evict_set,
    input  logic [WAY_W-1:0]           evict_way,
    input  logic [SET_W-1:0]           rd_set,
    output logic [WAYS-1:0]            rd_valid,
    output logic [WAYS-1:0][CNT_W-1:0] rd_loc,
    output logic [CNT_W-1:0]           rd_glb
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_SETS-1:0][CNT_W-1:0]            glb_all;
    logic [NUM_SETS-1:0][WAYS-1:0][CNT_W-1:0]  loc_all;
    logic [NUM_SETS-1:0][WAYS-1:0]             vld_all;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [CNT_W-1:0]            glb_q;
        logic [WAYS-1:0][CNT_W-1:0]  loc_q;
        logic [WAYS-1:0]             vld_q;
        logic                        acc_here;
        logic                        ev_here;
        logic                        halve;

        assign acc_here = acc_valid && (acc_set == SET_W'(s));
        assign ev_here  = evict_en && (evict_set == SET_W'(s));
        assign halve    = acc_here && (glb_q == CNT_MAX);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                glb_q <= '0;
                loc_q <= '0;
                vld_q <= '0;
            end else begin
                if (acc_here)
                    glb_q <= (halve ? (glb_q >> 1) : glb_q) + CNT_W'(1);
                for (int w = 0; w < WAYS; w++) begin
                    if (ev_here && evict_way == WAY_W'(w)) begin
                        loc_q[w] <= '0;
                        vld_q[w] <= 1'b1;
                    end else if (acc_here && acc_hit && acc_way == WAY_W'(w)) begin
                        loc_q[w] <= (halve ? (loc_q[w] >> 1) : loc_q[w]) + CNT_W'(1);
                    end else if (halve) begin
                        loc_q[w] <= loc_q[w] >> 1;
                    end
                end
            end
        end

        assign glb_all[s] = glb_q;
        assign loc_all[s] = loc_q;
        assign vld_all[s] = vld_q;
    end

    assign rd_glb   = glb_all[rd_set];
    assign rd_loc   = loc_all[rd_set];
    assign rd_valid = vld_all[rd_set];
endmodule

// File: rtl/rate_victim_sel.sv
module rate_victim_sel
    import rvs_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int WAYS     = 4,
    parameter int CNT_W    = 8,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             fill_req,
    input  logic [SET_W-1:0] fill_set,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way
);
    grant_state_e               state_q, state_d;
    logic [15:0]                lfsr_q;
    logic [WAYS-1:0]            rd_valid;
    logic [WAYS-1:0][CNT_W-1:0] rd_loc;
    logic [CNT_W-1:0]           rd_glb;
    logic [WAY_W-1:0]           pick_way;
    logic [WAY_W-1:0]           way_q;

    rvs_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_q)
    );

    rvs_set_stats #(.NUM_SETS(NUM_SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_set   (acc_set),
        .acc_hit   (acc_hit),
        .acc_way   (acc_way),
        .evict_en  (fill_req),
        .evict_set (fill_set),
        .evict_way (pick_way),
        .rd_set    (fill_set),
        .rd_valid  (rd_valid),
        .rd_loc    (rd_loc),
        .rd_glb    (rd_glb)
    );

    rvs_pick #(.WAYS(WAYS), .CNT_W(CNT_W)) u_pick (
        .valid (rd_valid),
        .loc   (rd_loc),
        .rnd   (lfsr_q[WAY_W-1:0]),
        .way   (pick_way)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (fill_req) state_d = S_GRANT;
            S_GRANT: state_d = fill_req ? S_GRANT : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            way_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fill_req) way_q <= pick_way;
        end
    end

    always_comb begin
        victim_valid = (state_q == S_GRANT);
        victim_way   = way_q;
    end
endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fill_req,
    input logic                       victim_valid,
    input logic [WAY_W-1:0]           victim_way,
    input logic [WAYS-1:0]            sel_valid,
    input logic [WAYS-1:0][CNT_W-1:0] sel_loc,
    input logic [CNT_W-1:0]           sel_glb,
    input logic [15:0]                lfsr
);
    logic [WAYS-1:0]            valid_q;
    logic [WAYS-1:0][CNT_W-1:0] loc_q;
    logic [WAY_W-1:0]           low_inv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            loc_q   <= '0;
        end else if (fill_req) begin
            valid_q <= sel_valid;
            loc_q   <= sel_loc;
        end
    end

    always_comb begin
        low_inv = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid_q[w]) low_inv = WAY_W'(w);
    end

    assert_grant_after_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> victim_valid);

    assert_quiet_without_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_req |=> !victim_valid);

    assert_invalid_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !(&valid_q)) |-> (victim_way == low_inv));

    assert_lfsr_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != 16'h0000);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assert_min_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (victim_valid && (&valid_q)) |-> (loc_q[victim_way] <= loc_q[w]));

        assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            sel_loc[w] <= sel_glb);
    end
endmodule

bind rate_victim_sel rvs_checker #(.WAYS(WAYS), .CNT_W(CNT_W)) u_rvs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_req     (fill_req),
    .victim_valid (victim_valid),
    .victim_way   (victim_way),
    .sel_valid    (rd_valid),
    .sel_loc      (rd_loc),
    .sel_glb      (rd_glb),
    .lfsr         (lfsr_q)
);

// File: tb/rate_victim_sel_bench.sv
module rate_victim_sel_bench;
    localparam int NS = 8;
    localparam int NW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_set = '0;
    logic       acc_hit = 1'b0;
    logic [1:0] acc_way = '0;
    logic       fill_req = 1'b0;
    logic [2:0] fill_set = '0;
    logic       victim_valid;
    logic [1:0] victim_way;

    int checks = 0;
    int failures = 0;

    int m_glb [NS];
    int m_loc [NS][NW];
    bit m_vld [NS][NW];

    logic [3:0] exp_q [$];
    string      tag_q [$];
    logic [3:0] seen_ways;

    always #10 clk = ~clk;

    rate_victim_sel #(.NUM_SETS(NS), .WAYS(NW), .CNT_W(8)) u_rate_victim_sel (
        .clk, .rst_n, .acc_valid, .acc_set, .acc_hit, .acc_way,
        .fill_req, .fill_set, .victim_valid, .victim_way
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop one expected mask per presented victim
    always @(negedge clk) begin
        if (rst_n && victim_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected victim", 1, 0);
            end else begin
                logic [3:0] m;
                string      t;
                m = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(m[victim_way], t, int'(victim_way), int'(m));
            end
        end
    end

    task automatic access(input int s, input bit hit, input int w);
        @(negedge clk);
        acc_valid = 1'b1; acc_set = 3'(s); acc_hit = hit; acc_way = 2'(w);
        @(negedge clk);
        acc_valid = 1'b0; acc_hit = 1'b0;
        if (m_glb[s] == 255) begin
            m_glb[s] = m_glb[s] / 2;
            for (int k = 0; k < NW; k++) m_loc[s][k] = m_loc[s][k] / 2;
        end
        m_glb[s]++;
        if (hit) m_loc[s][w]++;
    endtask

    task automatic fill(input int s, input string tag);
        logic [3:0] mask;
        int         mn;
        mask = '0;
        for (int k = NW - 1; k >= 0; k--)
            if (!m_vld[s][k]) mask = 4'(1 << k);
        if (mask == 0) begin
            mn = 1000;
            for (int k = 0; k < NW; k++) if (m_loc[s][k] < mn) mn = m_loc[s][k];
            for (int k = 0; k < NW; k++) if (m_loc[s][k] == mn) mask[k] = 1'b1;
        end
        @(negedge clk);
        exp_q.push_back(mask);
        tag_q.push_back(tag);
        fill_req = 1'b1; fill_set = 3'(s);
        @(negedge clk);
        fill_req = 1'b0;
        #1;
        chk(victim_valid == 1'b1, "R2 victim_valid after fill", int'(victim_valid), 1);
        m_loc[s][victim_way] = 0;
        m_vld[s][victim_way] = 1'b1;
        seen_ways[victim_way] = 1'b1;
        @(negedge clk);
        chk(victim_valid == 1'b0, "R2 victim_valid drops", int'(victim_valid), 0);
    endtask

    function automatic int popc(input logic [3:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
    endfunction

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_glb[s] = 0;
            for (int k = 0; k < NW; k++) begin m_loc[s][k] = 0; m_vld[s][k] = 1'b0; end
        end
        repeat (3) @(negedge clk);
        chk(victim_valid == 1'b0, "R1 reset victim_valid", int'(victim_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(victim_valid == 1'b0, "R1 idle after reset", int'(victim_valid), 0);

        // R3: empty ways claimed in index order
        for (int k = 0; k < NW; k++) fill(0, "R3 invalid way first");

        // R4/R6: unique minimum after hits and misses in set 1
        for (int k = 0; k < NW; k++) fill(1, "R3 fill set 1");
        repeat (3) access(1, 1'b1, 0);
        repeat (1) access(1, 1'b1, 1);
        repeat (2) access(1, 1'b1, 2);
        repeat (5) access(1, 1'b1, 3);
        repeat (6) access(1, 1'b0, 0);
        // R9: heavy traffic to set 5 must not move set 1
        for (int k = 0; k < NW; k++) fill(5, "R3 fill set 5");
        repeat (9) access(5, 1'b1, 0);
        repeat (9) access(5, 1'b1, 2);
        fill(1, "R4 least referenced way");
        // R7: refilled way restarts at zero and loses again
        fill(1, "R7 history discarded");
        access(1, 1'b1, 0);
        fill(1, "R9 set 1 unaffected by set 5");
        fill(5, "R4 set 5 minimum");

        // R5: four-way tie
        for (int k = 0; k < NW; k++) fill(2, "R3 fill set 2");
        seen_ways = '0;
        for (int n = 0; n < 12; n++) begin
            fill(2, "R5 victim within tie");
            repeat (n % 3) @(negedge clk);
        end
        chk(popc(seen_ways) >= 2, "R5 tie spread over ways", popc(seen_ways), 2);

        // R8: halving at global overflow in set 3
        for (int k = 0; k < NW; k++) fill(3, "R3 fill set 3");
        access(3, 1'b1, 1);
        repeat (2) access(3, 1'b1, 2);
        repeat (2) access(3, 1'b1, 3);
        repeat (250) access(3, 1'b0, 0);
        fill(3, "R8 before halving");
        chk(m_glb[3] == 255, "R8 model global at limit", m_glb[3], 255);
        access(3, 1'b0, 0);
        seen_ways = '0;
        for (int n = 0; n < 12; n++) begin
            fill(3, "R8 halved tie");
            repeat (n % 3) @(negedge clk);
        end
        chk(seen_ways == 4'b0011, "R8 both halved ways chosen", int'(seen_ways), 3);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 every fill answered", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule